// File: doc/BRIEF.md
# Credit-Weighted CPU/DMA Memory Port Arbiter

This block decides which of two requesters, a processor and a DMA engine, owns a shared memory port for the next burst. The decision rests on a signed credit account kept for the processor. Every clock the account is lowered by a programmable drain step. Every charged processor grant raises it by a programmable weight times the number of data cycles in the burst, which is half the burst length. While the account is at or below a programmable priority threshold, the processor beats the DMA engine. Above the threshold, a pending DMA request goes first, and the processor is served only when the DMA engine is idle.

The account may fall below zero, so an idle DMA side lets the processor borrow against its future share. A programmable debt limit sets a floor that the account never passes. When the account sits on that floor and no DMA request is pending, a processor grant carries no charge, so the processor's bandwidth is free and the account keeps the value it had. The account saturates at its largest positive value.

A decision is made only while the port is idle. A grant stays up until the memory side pulses transfer-done. The configuration inputs are captured only while no transfer is in progress.

Top module: `mem_credit_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `credit_acct` reads 0 and neither `cpu_gnt` nor `dma_gnt` is high.
- R2: On every clock edge with no charged processor grant, the account falls by the captured drain step, unless that would take it below the floor.
- R3: On the edge where a charged processor grant is issued, the account changes by `ratio * floor(blen/2) - drain`, where `blen` is `cpu_blen` as sampled at that edge.
- R4: The account, read as two's complement, is never below the floor `-cfg_debt_max`. A result below the floor is clamped to the floor.
- R5: A processor grant issued while the account equals the floor and `dma_req` is low is free: no charge is added and the account stays at the floor.
- R6: From idle, if both request, the processor wins when the signed account is at or below the signed `cfg_limit`, and the DMA engine wins otherwise. A lone request always wins.
- R7: A grant rises one cycle after an idle-port request, stays high whatever the requests do, and falls in the cycle after the edge that samples `xfer_done` high. `xfer_done` on an idle port has no effect, and the two grants are never high together.
- R8: Configuration changes made while a grant is held do not affect the drain, charge, floor or threshold until the port is idle again.
- R9: The account saturates at 2^(ACC_W-1)-1 and never wraps to a negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| dma_req | input | 1 | DMA engine request |
| cpu_blen | input | BLEN_W | Processor burst length in beats |
| cfg_ratio | input | RATIO_W | Charge weight per data cycle |
| cfg_decr | input | DECR_W | Drain step per clock |
| cfg_limit | input | ACC_W | Signed priority threshold |
| cfg_debt_max | input | ACC_W-1 | Largest debt magnitude; the floor is its negative |
| xfer_done | input | 1 | One-cycle pulse ending the current burst |
| cpu_gnt | output | 1 | Processor owns the port |
| dma_gnt | output | 1 | DMA engine owns the port |
| credit_acct | output | ACC_W | Signed processor credit account |

## Verification
The bench builds the arbiter with a 16-bit account, an 8-bit weight and an 8-bit drain, a 6-bit burst length, and the shift-and-add charge multiplier. With these sizes, a weight of 255 and a 63-beat burst give a charge of 7905, so the positive saturation point is reached after a handful of grants. A 50-count floor is reached within a few dozen drain cycles, which brings the free-grant and clamp corner cases into a short run. The threshold is moved below the floor to force the DMA-first path while the account is deep in debt.

// File: rtl/mca_pkg.sv
`timescale 1ns/1ps
package mca_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_DMA  = 2'd2
   } owner_e;
endpackage

// File: rtl/mca_cfg_snap.sv
`timescale 1ns/1ps
// Captures configuration while the port is idle; frozen during a transfer.
module mca_cfg_snap #(
   parameter int ACC_W   = 16,
   parameter int RATIO_W = 8,
   parameter int DECR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [RATIO_W-1:0] in_ratio,
   input  logic [DECR_W-1:0]  in_decr,
   input  logic [ACC_W-1:0]   in_limit,
   input  logic [ACC_W-2:0]   in_debt,
   output logic [RATIO_W-1:0] s_ratio,
   output logic [DECR_W-1:0]  s_decr,
   output logic [ACC_W-1:0]   s_limit,
   output logic [ACC_W-2:0]   s_debt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ratio <= '0;
         s_decr  <= '0;
         s_limit <= '0;
         s_debt  <= '0;
      end else if (load_en) begin
         s_ratio <= in_ratio;
         s_decr  <= in_decr;
         s_limit <= in_limit;
         s_debt  <= in_debt;
      end
   end

   // R8: nothing captured while a transfer holds the port
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable({s_ratio, s_decr, s_limit, s_debt}));
endmodule

// File: rtl/mca_credit.sv
`timescale 1ns/1ps
// Signed credit account: per-clock drain, per-grant charge, floor clamp, top saturation.
module mca_credit #(
   parameter int ACC_W     = 16,
   parameter int RATIO_W   = 8,
   parameter int DECR_W    = 8,
   parameter int BLEN_W    = 6,
   parameter int MUL_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               charge_en,
   input  logic [BLEN_W-1:0]  blen,
   input  logic [RATIO_W-1:0] ratio,
   input  logic [DECR_W-1:0]  decr,
   input  logic [ACC_W-2:0]   debt_max,
   output logic [ACC_W-1:0]   acc_q,
   output logic               at_floor
);
   localparam int HALF_W = BLEN_W - 1;
   localparam int CHG_W  = RATIO_W + HALF_W;
   localparam int EXT_W  = ACC_W + 2;

   logic [HALF_W-1:0] half_cyc;
   logic [CHG_W-1:0]  prod;
   logic [ACC_W-1:0]  floor_v;
   logic signed [EXT_W-1:0] acc_x, decr_x, chg_x, floor_x, max_x, sum_x, nxt_x;

   assign half_cyc = HALF_W'(blen >> 1);

   generate
      if (MUL_STYLE == 0) begin : g_mul_direct
         assign prod = CHG_W'(ratio) * CHG_W'(half_cyc);
      end else begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int i = 0; i < RATIO_W; i++) begin
               if (ratio[i]) prod = prod + (CHG_W'(half_cyc) << i);
            end
         end
      end
   endgenerate

   assign floor_v = '0 - {1'b0, debt_max};
   assign acc_x   = {{2{acc_q[ACC_W-1]}}, acc_q};
   assign floor_x = {{2{floor_v[ACC_W-1]}}, floor_v};
   assign decr_x  = {{(EXT_W-DECR_W){1'b0}}, decr};
   assign chg_x   = charge_en ? {{(EXT_W-CHG_W){1'b0}}, prod} : '0;
   assign max_x   = {3'b000, {(ACC_W-1){1'b1}}};
   assign sum_x   = acc_x - decr_x + chg_x;

   always_comb begin
      if (sum_x > max_x)        nxt_x = max_x;
      else if (sum_x < floor_x) nxt_x = floor_x;
      else                      nxt_x = sum_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= nxt_x[ACC_W-1:0];
   end

   assign at_floor = (acc_q == floor_v);

   // R4: account never below the floor in force at the edge that wrote it
   a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !($signed(acc_q) < $signed($past(floor_v))));

   // R2: plain drain when no charge and the floor is not reached
   a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (!charge_en && (acc_x - decr_x >= floor_x))
      |=> (acc_q == $past(acc_q) - ACC_W'($past(decr))));

   // R3: a charge larger than the drain raises an unsaturated account
   a_r3_charge_up: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_en && (CHG_W'(decr) < prod) && (acc_x < max_x))
      |=> ($signed(acc_q) > $signed($past(acc_q))));

   // R9: a non-negative account that gains net credit stays non-negative
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_q[ACC_W-1] && charge_en && (CHG_W'(decr) <= prod))
      |=> !acc_q[ACC_W-1]);
endmodule

// File: rtl/mca_pick.sv
`timescale 1ns/1ps
// Idle-only decision and grant hold until transfer-done.
module mca_pick
   import mca_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic dma_req,
   input  logic xfer_done,
   input  logic cpu_first,
   input  logic at_floor,
   output logic cpu_gnt,
   output logic dma_gnt,
   output logic busy,
   output logic cpu_take,
   output logic cpu_free_start
);
   owner_e owner_q;
   logic   start, cpu_win, free_now;

   assign busy     = (owner_q != OWN_IDLE);
   assign start    = !busy && (cpu_req || dma_req);
   assign cpu_win  = cpu_req && (cpu_first || !dma_req);
   assign free_now = cpu_win && at_floor && !dma_req;

   assign cpu_take       = start && cpu_win && !free_now;
   assign cpu_free_start = start && free_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
      end else if (busy) begin
         if (xfer_done) owner_q <= OWN_IDLE;
      end else if (start) begin
         owner_q <= cpu_win ? OWN_CPU : OWN_DMA;
      end
   end

   assign cpu_gnt = (owner_q == OWN_CPU);
   assign dma_gnt = (owner_q == OWN_DMA);

   // R6: priority by account versus threshold
   a_r6_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cpu_req && dma_req && cpu_first) |=> cpu_gnt);
   a_r6_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && dma_req && !cpu_first) |=> dma_gnt);

   // R7: grant held until done, dropped right after done
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !xfer_done) |=> ($stable(cpu_gnt) && $stable(dma_gnt)));
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_done) |=> (!cpu_gnt && !dma_gnt));
   a_r7_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cpu_req && !dma_req) |=> !busy);
endmodule

// File: rtl/mem_credit_arbiter.sv
`timescale 1ns/1ps
module mem_credit_arbiter #(
   parameter int ACC_W     = 16,
   parameter int RATIO_W   = 8,
   parameter int DECR_W    = 8,
   parameter int BLEN_W    = 6,
   parameter int MUL_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               dma_req,
   input  logic [BLEN_W-1:0]  cpu_blen,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic [DECR_W-1:0]  cfg_decr,
   input  logic [ACC_W-1:0]   cfg_limit,
   input  logic [ACC_W-2:0]   cfg_debt_max,
   input  logic               xfer_done,
   output logic               cpu_gnt,
   output logic               dma_gnt,
   output logic [ACC_W-1:0]   credit_acct
);
   localparam int CHG_W = RATIO_W + BLEN_W - 1;

   generate
      if (ACC_W < 16) begin : g_chk_acc
         $error("mem_credit_arbiter: ACC_W must be at least 16");
      end
      if (BLEN_W < 2) begin : g_chk_blen
         $error("mem_credit_arbiter: BLEN_W must be at least 2");
      end
      if (CHG_W > ACC_W - 2) begin : g_chk_chg
         $error("mem_credit_arbiter: charge width too large for account");
      end
      if (DECR_W > ACC_W - 2) begin : g_chk_decr
         $error("mem_credit_arbiter: drain width too large for account");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_chk_mul
         $error("mem_credit_arbiter: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [RATIO_W-1:0] s_ratio;
   logic [DECR_W-1:0]  s_decr;
   logic [ACC_W-1:0]   s_limit;
   logic [ACC_W-2:0]   s_debt;
   logic busy, cpu_take, cpu_free_start, at_floor, cpu_first;

   mca_cfg_snap #(.ACC_W(ACC_W), .RATIO_W(RATIO_W), .DECR_W(DECR_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (!busy),
      .in_ratio (cfg_ratio),
      .in_decr  (cfg_decr),
      .in_limit (cfg_limit),
      .in_debt  (cfg_debt_max),
      .s_ratio  (s_ratio),
      .s_decr   (s_decr),
      .s_limit  (s_limit),
      .s_debt   (s_debt)
   );

   mca_credit #(.ACC_W(ACC_W), .RATIO_W(RATIO_W), .DECR_W(DECR_W),
                .BLEN_W(BLEN_W), .MUL_STYLE(MUL_STYLE)) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .charge_en (cpu_take),
      .blen      (cpu_blen),
      .ratio     (s_ratio),
      .decr      (s_decr),
      .debt_max  (s_debt),
      .acc_q     (credit_acct),
      .at_floor  (at_floor)
   );

   assign cpu_first = ($signed(credit_acct) <= $signed(s_limit));

   mca_pick u_pick (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req        (cpu_req),
      .dma_req        (dma_req),
      .xfer_done      (xfer_done),
      .cpu_first      (cpu_first),
      .at_floor       (at_floor),
      .cpu_gnt        (cpu_gnt),
      .dma_gnt        (dma_gnt),
      .busy           (busy),
      .cpu_take       (cpu_take),
      .cpu_free_start (cpu_free_start)
   );

   // R5: a free grant leaves the account where it was
   a_r5_free: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_free_start |=> (credit_acct == $past(credit_acct)));

   // R7: never both grants
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> !(cpu_gnt && dma_gnt));
endmodule

// File: tb/mem_credit_arbiter_test.sv
`timescale 1ns/1ps
module mem_credit_arbiter_test;
   localparam int ACC_W = 16, RATIO_W = 8, DECR_W = 8, BLEN_W = 6;
   localparam int MAXV  = (1 << (ACC_W - 1)) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, dma_req = 1'b0, xfer_done = 1'b0;
   logic [BLEN_W-1:0]  cpu_blen = 6'd8;
   logic [RATIO_W-1:0] cfg_ratio = 8'd2;
   logic [DECR_W-1:0]  cfg_decr = 8'd3;
   logic [ACC_W-1:0]   cfg_limit = 16'd0;
   logic [ACC_W-2:0]   cfg_debt_max = 15'd50;
   logic cpu_gnt, dma_gnt;
   logic [ACC_W-1:0] credit_acct;

   mem_credit_arbiter #(.ACC_W(ACC_W), .RATIO_W(RATIO_W), .DECR_W(DECR_W),
                        .BLEN_W(BLEN_W), .MUL_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
      .cpu_blen(cpu_blen), .cfg_ratio(cfg_ratio), .cfg_decr(cfg_decr),
      .cfg_limit(cfg_limit), .cfg_debt_max(cfg_debt_max), .xfer_done(xfer_done),
      .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .credit_acct(credit_acct)
   );

   // Reference built from the requirements
   int m_acc = 0;
   bit m_busy = 0, m_cpu = 0, m_dma = 0;
   int s_ratio = 0, s_decr = 0, s_limit = 0, s_debt = 0;

   always @(posedge clk) begin
      int nxt, chg;
      bit st, cw, fr;
      if (!rst_n) begin
         m_acc = 0; m_busy = 0; m_cpu = 0; m_dma = 0;
         s_ratio = 0; s_decr = 0; s_limit = 0; s_debt = 0;
      end else begin
         st  = !m_busy && (cpu_req || dma_req);
         cw  = cpu_req && ((m_acc <= s_limit) || !dma_req);
         fr  = cw && (m_acc == -s_debt) && !dma_req;
         chg = (st && cw && !fr) ? s_ratio * (int'(cpu_blen) / 2) : 0;
         nxt = m_acc - s_decr + chg;
         if (nxt > MAXV) nxt = MAXV;
         if (nxt < -s_debt) nxt = -s_debt;
         if (!m_busy) begin
            s_ratio = int'(cfg_ratio);
            s_decr  = int'(cfg_decr);
            s_limit = int'($signed(cfg_limit));
            s_debt  = int'(cfg_debt_max);
         end
         if (m_busy) begin
            if (xfer_done) begin m_busy = 0; m_cpu = 0; m_dma = 0; end
         end else if (st) begin
            m_busy = 1; m_cpu = cw; m_dma = !cw;
         end
         m_acc = nxt;
      end
   end

   int nchk = 0, nerr = 0;
   bit finished = 0;

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int acct();
      return int'($signed(credit_acct));
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmp_model(input string req);
      check({req, " account"}, acct(), m_acc);
      check({req, " grants"}, int'({cpu_gnt, dma_gnt}), int'({m_cpu, m_dma}));
   endtask

   typedef struct packed {
      logic       cpu;
      logic       dma;
      logic [5:0] blen;
      logic [3:0] hold;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{1'b1, 1'b0, 6'd8,  4'd2},
      '{1'b1, 1'b1, 6'd16, 4'd1},
      '{1'b0, 1'b1, 6'd4,  4'd3},
      '{1'b1, 1'b1, 6'd32, 4'd0},
      '{1'b1, 1'b1, 6'd62, 4'd2},
      '{1'b0, 1'b1, 6'd8,  4'd1},
      '{1'b1, 1'b0, 6'd63, 4'd4},
      '{1'b1, 1'b1, 6'd2,  4'd1},
      '{1'b1, 1'b1, 6'd9,  4'd5},
      '{1'b0, 1'b1, 6'd1,  4'd0}
   };

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         nerr++;
         $display("FAIL R7 watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: reset state
      check("R1 account", acct(), 0);
      check("R1 grants", int'({cpu_gnt, dma_gnt}), 0);
      rst_n = 1'b1;
      step(1);
      check("R1 first cycle account", acct(), 0);
      step(3);
      // R2: snapshot holds drain 0 for the first edge, then 3 per clock
      check("R2 drain", acct(), -9);
      cmp_model("R2");
      step(20);
      check("R4 floor clamp", acct(), -50);

      // R7: done on idle port ignored
      xfer_done = 1'b1; step(1); xfer_done = 1'b0;
      check("R7 idle done grants", int'({cpu_gnt, dma_gnt}), 0);

      // R5: free grant at floor with DMA idle
      cpu_req = 1'b1; step(1);
      check("R5 free grant", int'(cpu_gnt), 1);
      check("R5 free account", acct(), -50);
      cpu_req = 1'b0; step(2);
      check("R7 grant held", int'(cpu_gnt), 1);
      xfer_done = 1'b1; step(1); xfer_done = 1'b0;
      check("R7 grant released", int'({cpu_gnt, dma_gnt}), 0);
      step(1);

      // R3: charged grant, both requesting, account below limit
      cpu_req = 1'b1; dma_req = 1'b1; step(1);
      check("R6 cpu wins at or below limit", int'({cpu_gnt, dma_gnt}), 2);
      check("R3 charge", acct(), -45);
      cpu_req = 1'b0; dma_req = 1'b0;
      // R8: drain change during transfer has no effect
      cfg_decr = 8'd0; step(1);
      check("R8 frozen drain", acct(), -48);
      xfer_done = 1'b1; step(1); xfer_done = 1'b0;
      check("R4 clamp after release", acct(), -50);
      cfg_decr = 8'd3; step(3);
      cmp_model("R8");

      // R6: limit below account, DMA first
      cfg_limit = 16'hFF9C; step(2);
      cpu_req = 1'b1; dma_req = 1'b1; step(1);
      check("R6 dma wins above limit", int'({cpu_gnt, dma_gnt}), 1);
      cpu_req = 1'b0; dma_req = 1'b0;
      xfer_done = 1'b1; step(1); xfer_done = 1'b0; step(1);
      cpu_req = 1'b1; step(1);
      check("R6 lone cpu above limit", int'({cpu_gnt, dma_gnt}), 2);
      cpu_req = 1'b0;
      xfer_done = 1'b1; step(1); xfer_done = 1'b0; step(1);

      // Vector walk
      cfg_ratio = 8'd3; cfg_decr = 8'd1; cfg_limit = 16'd20; cfg_debt_max = 15'd200;
      step(3);
      for (int i = 0; i < 10; i++) begin
         cpu_req = VECS[i].cpu; dma_req = VECS[i].dma; cpu_blen = VECS[i].blen;
         step(1);
         cmp_model("R6 R3 vector");
         cpu_req = 1'b0; dma_req = 1'b0;
         step(int'(VECS[i].hold));
         xfer_done = 1'b1; step(1); xfer_done = 1'b0;
         step(1);
         cmp_model("R7 R2 vector");
      end

      // R9: saturation at the top
      cfg_decr = 8'd0; cfg_ratio = 8'd255; cfg_debt_max = 15'd1000;
      cfg_limit = 16'h7FFF; cpu_blen = 6'd63;
      step(2);
      for (int k = 0; k < 7; k++) begin
         cpu_req = 1'b1; step(1);
         cpu_req = 1'b0;
         xfer_done = 1'b1; step(1); xfer_done = 1'b0; step(1);
         cmp_model("R9 climb");
      end
      check("R9 saturated", acct(), MAXV);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule